// File: doc/BRIEF.md
# Keyed-Hash Configuration and Secret-Key Register Bank

This block holds the software-programmed settings and the secret key of a keyed hash engine. Software reaches it through a simple word-addressed write port and a combinational read port. It stores a configuration word and decodes the one-hot digest-size and key-length fields into selections that are always valid. It also caps the key length against the block size of the chosen digest. The block holds a 1024-bit key built from 32-bit words. It turns command writes into single-cycle pulses, and it lets software scramble the key in place by XOR with a value it supplies.

The engine reports whether it is idle. While it is not idle, the bank guards its state. Configuration writes are dropped without notice. Key writes are dropped and a one-cycle error pulse is raised. The key is never readable through the read port. The hash computation itself sits outside this block.

Word address map: 0 holds the configuration, 1 takes commands, 2 takes the wipe value, and 32 to 63 hold the key words.

Top module: `hkey_regbank`

## Requirements
- R1: After reset the configuration word reads 0x210. The digest selection is 4'b0001 and the key-length selection is 5'b00010. Both enables and both swap controls are 0, the key vector is all zero, and no command or error pulse is high.
- R2: An idle write to address 0 stores the low 13 bits of the configuration word. Bit 0 is the keyed-mode enable, bit 1 the hash enable, bit 2 the input byte swap and bit 3 the output byte swap. Bits 7:4 hold the digest size and bits 12:8 the key length. The new values show on the outputs after the clock edge that takes the write. Reading address 0 returns the stored bits, with bits 31:13 as zero.
- R3: The digest selection equals the stored digest field when that field is 4'b0010 (256), 4'b0100 (384) or 4'b1000 (512). For every other value it is 4'b0001 (none).
- R4: The key-length field codes 128, 256, 384, 512 and 1024 bits on bits 0 to 4. When exactly one bit is set, the selection follows it. A zero field or a field with several bits set selects 5'b00010 (256).
- R5: When the digest selection is 256, a 1024-bit key length is reduced to 5'b01000 (512). With any other digest selection the key length is not capped.
- R6: A configuration write made while the engine is not idle is discarded. No output changes, the readback is unchanged, and no error pulse is raised.
- R7: An idle write to address 32+i loads key word i. The key vector is {word0, word1, ..., word31}, so word 0 forms bits 1023:992.
- R8: A key write made while the engine is not idle leaves the key unchanged. The error output is high for exactly the one cycle after the clock edge that takes that write. Idle key writes never raise it.
- R9: Writing address 1 gives a one-cycle pulse on each command output whose data bit is 1. Bit 0 is start, bit 1 process, bit 2 stop and bit 3 continue. Several bits may pulse together. Address 1 reads as zero.
- R10: A write to address 2 XORs the written value into every key word in one cycle, whether or not the engine is idle. A value of zero leaves the key unchanged.
- R11: Key addresses and the wipe address read as zero, whatever the key holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | 7 | Word address for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| engineIdle | input | 1 | High when the hash engine is idle |
| hmacEnable | output | 1 | Keyed-mode enable |
| shaEnable | output | 1 | Hash enable |
| inByteSwap | output | 1 | Message byte-order swap |
| outByteSwap | output | 1 | Digest byte-order swap |
| digestSel | output | 4 | Normalised one-hot digest size |
| keyLenSel | output | 5 | Normalised, capped one-hot key length |
| keyVec | output | 1024 | Secret key, word 0 most significant |
| cmdStart | output | 1 | Start command pulse |
| cmdProcess | output | 1 | Process command pulse |
| cmdStop | output | 1 | Stop command pulse |
| cmdContinue | output | 1 | Continue command pulse |
| keyWrErr | output | 1 | Pulse for a key write rejected while busy |

## Verification
The hardest case to reach from the ports is the interplay between the engine becoming busy and software access. A write must land in a cycle where engineIdle is low, and the bench must then show that nothing moved. The bench lowers engineIdle between directed write tasks and issues configuration, key and wipe writes during the busy window. It then confirms, through readback and the key vector, that configuration and key are untouched while the wipe still takes effect. The normalisation corners are covered by sweeping all 16 digest codes and all 32 key-length codes, including the 256-digest cap.

// File: rtl/hkey_pkg.sv
package hkey_pkg;
  parameter int unsigned DataW       = 32;
  parameter int unsigned AddrW       = 7;
  parameter int unsigned NumKeyWords = 32;
  parameter int unsigned KeyIdxW     = $clog2(NumKeyWords);
  parameter int unsigned KeyW        = DataW * NumKeyWords;
  parameter int unsigned CmdW        = 4;
  parameter int unsigned DigW        = 4;
  parameter int unsigned KlenW       = 5;

  parameter logic [AddrW-1:0] ADDR_CFG  = 7'd0;
  parameter logic [AddrW-1:0] ADDR_CMD  = 7'd1;
  parameter logic [AddrW-1:0] ADDR_WIPE = 7'd2;
  parameter logic [AddrW-1:0] KEY_BASE  = 7'd32;

  parameter logic [DigW-1:0]  DIG_NONE = 4'b0001;
  parameter logic [DigW-1:0]  DIG_256  = 4'b0010;
  parameter logic [DigW-1:0]  DIG_384  = 4'b0100;
  parameter logic [DigW-1:0]  DIG_512  = 4'b1000;
  parameter logic [KlenW-1:0] KLEN_256  = 5'b00010;
  parameter logic [KlenW-1:0] KLEN_512  = 5'b01000;
  parameter logic [KlenW-1:0] KLEN_1024 = 5'b10000;

  // Stored configuration word; hmacEn is bit 0.
  typedef struct packed {
    logic [KlenW-1:0] keyLen;
    logic [DigW-1:0]  digest;
    logic             digestSwap;
    logic             endianSwap;
    logic             shaEn;
    logic             hmacEn;
  } cfgReg_t;

  parameter int unsigned CfgW = $bits(cfgReg_t);
  parameter cfgReg_t CFG_RESET = cfgReg_t'(13'h210);

  // Write strobes from control to datapath.
  typedef struct packed {
    logic               cfgWr;
    logic               keyWr;
    logic               wipeWr;
    logic [KeyIdxW-1:0] keyIdx;
  } regStrobe_t;

  function automatic logic [DigW-1:0] normDigest(input logic [DigW-1:0] raw);
    case (raw)
      DIG_256, DIG_384, DIG_512: normDigest = raw;
      default:                   normDigest = DIG_NONE;
    endcase
  endfunction

  function automatic logic [KlenW-1:0] normKeyLen(input logic [KlenW-1:0] raw,
                                                  input logic [DigW-1:0]  dig);
    logic [KlenW-1:0] sel;
    sel = ($countones(raw) == 1) ? raw : KLEN_256;
    if (dig == DIG_256 && sel == KLEN_1024) sel = KLEN_512;
    normKeyLen = sel;
  endfunction
endpackage

// File: rtl/hkey_ctrl.sv
module hkey_ctrl
  import hkey_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busWrEn,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [CmdW-1:0]     cmdBits,
  input  logic                engineIdle,
  output regStrobe_t          strobe,
  output logic [CmdW-1:0]     cmdPulse,
  output logic                keyWrErr
);
  logic keyHit;

  always_comb begin
    keyHit = (busAddr >= KEY_BASE) &&
             ({1'b0, busAddr} < ({1'b0, KEY_BASE} + (AddrW+1)'(NumKeyWords)));
    strobe.cfgWr  = busWrEn && (busAddr == ADDR_CFG) && engineIdle;
    strobe.keyWr  = busWrEn && keyHit && engineIdle;
    strobe.wipeWr = busWrEn && (busAddr == ADDR_WIPE);
    strobe.keyIdx = KeyIdxW'(busAddr - KEY_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdPulse <= '0;
      keyWrErr <= 1'b0;
    end else begin
      cmdPulse <= (busWrEn && busAddr == ADDR_CMD) ? cmdBits : '0;
      keyWrErr <= busWrEn && keyHit && !engineIdle;
    end
  end
endmodule

// File: rtl/hkey_datapath.sv
module hkey_datapath
  import hkey_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobe_t         strobe,
  input  logic [DataW-1:0]   wrData,
  input  logic [AddrW-1:0]   rdAddr,
  output logic [DataW-1:0]   rdData,
  output logic               hmacEnable,
  output logic               shaEnable,
  output logic               inByteSwap,
  output logic               outByteSwap,
  output logic [DigW-1:0]    digestSel,
  output logic [KlenW-1:0]   keyLenSel,
  output logic [KeyW-1:0]    keyVec
);
  cfgReg_t cfgQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfgQ <= CFG_RESET;
    else if (strobe.cfgWr) cfgQ <= cfgReg_t'(wrData[CfgW-1:0]);
  end

  for (genvar i = 0; i < NumKeyWords; i++) begin : g_key
    logic [DataW-1:0] keyWord;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        keyWord <= '0;
      else if (strobe.keyWr && strobe.keyIdx == KeyIdxW'(i))
        keyWord <= wrData;
      else if (strobe.wipeWr)
        keyWord <= keyWord ^ wrData;
    end
    assign keyVec[KeyW-1-DataW*i -: DataW] = keyWord;
  end

  always_comb begin
    hmacEnable  = cfgQ.hmacEn;
    shaEnable   = cfgQ.shaEn;
    inByteSwap  = cfgQ.endianSwap;
    outByteSwap = cfgQ.digestSwap;
    digestSel   = normDigest(cfgQ.digest);
    keyLenSel   = normKeyLen(cfgQ.keyLen, digestSel);
    rdData      = (rdAddr == ADDR_CFG) ? DataW'(cfgQ) : '0;
  end
endmodule

// File: rtl/hkey_regbank.sv
module hkey_regbank
  import hkey_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busWrEn,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [DataW-1:0]    busWrData,
  output logic [DataW-1:0]    busRdData,
  input  logic                engineIdle,
  output logic                hmacEnable,
  output logic                shaEnable,
  output logic                inByteSwap,
  output logic                outByteSwap,
  output logic [DigW-1:0]     digestSel,
  output logic [KlenW-1:0]    keyLenSel,
  output logic [KeyW-1:0]     keyVec,
  output logic                cmdStart,
  output logic                cmdProcess,
  output logic                cmdStop,
  output logic                cmdContinue,
  output logic                keyWrErr
);
  regStrobe_t      strobe;
  logic [CmdW-1:0] cmdPulse;

  hkey_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .cmdBits    (busWrData[CmdW-1:0]),
    .engineIdle (engineIdle),
    .strobe     (strobe),
    .cmdPulse   (cmdPulse),
    .keyWrErr   (keyWrErr)
  );

  hkey_datapath u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .wrData      (busWrData),
    .rdAddr      (busAddr),
    .rdData      (busRdData),
    .hmacEnable  (hmacEnable),
    .shaEnable   (shaEnable),
    .inByteSwap  (inByteSwap),
    .outByteSwap (outByteSwap),
    .digestSel   (digestSel),
    .keyLenSel   (keyLenSel),
    .keyVec      (keyVec)
  );

  assign cmdStart    = cmdPulse[0];
  assign cmdProcess  = cmdPulse[1];
  assign cmdStop     = cmdPulse[2];
  assign cmdContinue = cmdPulse[3];
endmodule

// File: rtl/hkey_regbank_chk.sv
module hkey_regbank_chk
  import hkey_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               busWrEn,
  input logic [AddrW-1:0]   busAddr,
  input logic [DataW-1:0]   busWrData,
  input logic               engineIdle,
  input logic [DigW-1:0]    digestSel,
  input logic [KlenW-1:0]   keyLenSel,
  input logic               hmacEnable,
  input logic               shaEnable,
  input logic [KeyW-1:0]    keyVec,
  input logic               cmdStart,
  input logic               cmdStop,
  input logic               keyWrErr
);
  logic keyHitC;
  assign keyHitC = (busAddr >= KEY_BASE) &&
                   ({1'b0, busAddr} < ({1'b0, KEY_BASE} + (AddrW+1)'(NumKeyWords)));

  assert_digest_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(digestSel) == 1);

  assert_keylen_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(keyLenSel) == 1);

  assert_cap_256_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (digestSel == DIG_256) |-> !keyLenSel[KlenW-1]);

  assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_CFG && !engineIdle) |=>
      ($stable(digestSel) && $stable(keyLenSel) && $stable(hmacEnable) && $stable(shaEnable)));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    keyWrErr |-> $past(busWrEn && keyHitC && !engineIdle));

  assert_busy_key_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && keyHitC && !engineIdle) |=> $stable(keyVec));

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_CMD && busWrData[0]) |=> cmdStart);

  assert_stop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdStop |-> $past(busWrEn && busAddr == ADDR_CMD && busWrData[2]));

  assert_wipe_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_WIPE && busWrData == '0) |=> $stable(keyVec));
endmodule

bind hkey_regbank hkey_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .engineIdle (engineIdle),
  .digestSel  (digestSel),
  .keyLenSel  (keyLenSel),
  .hmacEnable (hmacEnable),
  .shaEnable  (shaEnable),
  .keyVec     (keyVec),
  .cmdStart   (cmdStart),
  .cmdStop    (cmdStop),
  .keyWrErr   (keyWrErr)
);

// File: tb/tb_hkey_regbank.sv
module tb_hkey_regbank;
  import hkey_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busWrEn = 1'b0;
  logic [AddrW-1:0]  busAddr = '0;
  logic [DataW-1:0]  busWrData = '0;
  logic [DataW-1:0]  busRdData;
  logic              engineIdle = 1'b1;
  logic              hmacEnable, shaEnable, inByteSwap, outByteSwap;
  logic [DigW-1:0]   digestSel;
  logic [KlenW-1:0]  keyLenSel;
  logic [KeyW-1:0]   keyVec;
  logic              cmdStart, cmdProcess, cmdStop, cmdContinue, keyWrErr;

  int nChk = 0;
  int nErr = 0;
  logic [DataW-1:0] mKey [NumKeyWords];

  always #4 clk = ~clk;

  hkey_regbank dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AddrW-1:0] a, input logic [DataW-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [AddrW-1:0] a, output logic [DataW-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] cfgWord(input logic [4:0] kl, input logic [3:0] dg,
                                          input logic [3:0] flags);
    return {19'd0, kl, dg, flags};
  endfunction

  task automatic checkKeys(input string req);
    for (int i = 0; i < NumKeyWords; i++)
      chk(req, keyVec[KeyW-1-DataW*i -: DataW], mKey[i]);
  endtask

  task automatic tReset;
    logic [31:0] r;
    busRead(ADDR_CFG, r);
    chk("R1 cfg readback", r, 32'h210);
    chk("R1 digestSel", 32'(digestSel), 32'h1);
    chk("R1 keyLenSel", 32'(keyLenSel), 32'h2);
    chk("R1 flags", {28'd0, hmacEnable, shaEnable, inByteSwap, outByteSwap}, 32'h0);
    chk("R1 pulses", {27'd0, cmdStart, cmdProcess, cmdStop, cmdContinue, keyWrErr}, 32'h0);
    chk("R1 key zero", 32'(keyVec != '0), 32'h0);
  endtask

  task automatic tCfgFields;
    logic [31:0] r;
    busWrite(ADDR_CFG, 32'hFFFF_E000 | cfgWord(5'b00100, DIG_384, 4'b0101));
    chk("R2 hmacEnable", 32'(hmacEnable), 32'h1);
    chk("R2 shaEnable", 32'(shaEnable), 32'h0);
    chk("R2 inByteSwap", 32'(inByteSwap), 32'h1);
    chk("R2 outByteSwap", 32'(outByteSwap), 32'h0);
    busRead(ADDR_CFG, r);
    chk("R2 readback", r, cfgWord(5'b00100, DIG_384, 4'b0101));
    busWrite(ADDR_CFG, cfgWord(5'b00001, DIG_512, 4'b1010));
    chk("R2 flags b", {28'd0, hmacEnable, shaEnable, inByteSwap, outByteSwap}, 32'h5);
    chk("R2 digest b", 32'(digestSel), 32'(DIG_512));
  endtask

  task automatic tDigestNorm;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] e;
      e = (v == 2 || v == 4 || v == 8) ? 4'(v) : 4'b0001;
      busWrite(ADDR_CFG, cfgWord(5'b00010, 4'(v), 4'b0));
      chk("R3 digest norm", 32'(digestSel), 32'(e));
    end
  endtask

  task automatic tKeyLenNorm;
    for (int v = 0; v < 32; v++) begin
      logic [4:0] e;
      e = ($countones(5'(v)) == 1) ? 5'(v) : 5'b00010;
      busWrite(ADDR_CFG, cfgWord(5'(v), DIG_512, 4'b0));
      chk("R4 keylen norm", 32'(keyLenSel), 32'(e));
    end
  endtask

  task automatic tCap;
    busWrite(ADDR_CFG, cfgWord(KLEN_1024, DIG_256, 4'b0));
    chk("R5 cap 256", 32'(keyLenSel), 32'(KLEN_512));
    busWrite(ADDR_CFG, cfgWord(5'b00100, DIG_256, 4'b0));
    chk("R5 no cap small", 32'(keyLenSel), 32'h4);
    busWrite(ADDR_CFG, cfgWord(KLEN_1024, DIG_384, 4'b0));
    chk("R5 384 keeps 1024", 32'(keyLenSel), 32'(KLEN_1024));
    busWrite(ADDR_CFG, cfgWord(KLEN_1024, 4'b0110, 4'b0));
    chk("R5 none keeps 1024", 32'(keyLenSel), 32'(KLEN_1024));
  endtask

  task automatic tCfgLock;
    logic [31:0] r;
    busWrite(ADDR_CFG, cfgWord(5'b01000, DIG_512, 4'b1111));
    @(negedge clk); engineIdle = 1'b0;
    busWrite(ADDR_CFG, cfgWord(5'b00001, DIG_256, 4'b0000));
    chk("R6 err quiet", 32'(keyWrErr), 32'h0);
    chk("R6 flags kept", {28'd0, hmacEnable, shaEnable, inByteSwap, outByteSwap}, 32'hF);
    chk("R6 digest kept", 32'(digestSel), 32'(DIG_512));
    chk("R6 keylen kept", 32'(keyLenSel), 32'h8);
    busRead(ADDR_CFG, r);
    chk("R6 readback kept", r, cfgWord(5'b01000, DIG_512, 4'b1111));
    engineIdle = 1'b1;
  endtask

  task automatic tKeyOrder;
    for (int i = 0; i < NumKeyWords; i++) begin
      mKey[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0107);
      busWrite(KEY_BASE + AddrW'(i), mKey[i]);
      chk("R8 no err idle", 32'(keyWrErr), 32'h0);
    end
    chk("R7 word0 msb", keyVec[KeyW-1 -: DataW], mKey[0]);
    chk("R7 word31 lsb", keyVec[DataW-1:0], mKey[NumKeyWords-1]);
    checkKeys("R7 key order");
  endtask

  task automatic tKeyBusy;
    @(negedge clk); engineIdle = 1'b0;
    busWrite(KEY_BASE + 7'd5, 32'hDEAD_BEEF);
    chk("R8 err pulse", 32'(keyWrErr), 32'h1);
    @(negedge clk);
    chk("R8 err one cycle", 32'(keyWrErr), 32'h0);
    checkKeys("R8 key kept");
    engineIdle = 1'b1;
  endtask

  task automatic tCmd;
    logic [31:0] r;
    busWrite(ADDR_CMD, 32'h0000_000F);
    chk("R9 all pulse", {28'd0, cmdContinue, cmdStop, cmdProcess, cmdStart}, 32'hF);
    @(negedge clk);
    chk("R9 all clear", {28'd0, cmdContinue, cmdStop, cmdProcess, cmdStart}, 32'h0);
    busWrite(ADDR_CMD, 32'h0000_0005);
    chk("R9 start+stop", {28'd0, cmdContinue, cmdStop, cmdProcess, cmdStart}, 32'h5);
    busWrite(ADDR_CMD, 32'h0000_000A);
    chk("R9 process+continue", {28'd0, cmdContinue, cmdStop, cmdProcess, cmdStart}, 32'hA);
    busWrite(ADDR_CFG, 32'h0000_000F);
    chk("R9 no pulse other addr", {28'd0, cmdContinue, cmdStop, cmdProcess, cmdStart}, 32'h0);
    busRead(ADDR_CMD, r);
    chk("R9 reads zero", r, 32'h0);
  endtask

  task automatic tWipe;
    busWrite(ADDR_WIPE, 32'h0);
    checkKeys("R10 zero wipe");
    busWrite(ADDR_WIPE, 32'h1234_5678);
    for (int i = 0; i < NumKeyWords; i++) mKey[i] ^= 32'h1234_5678;
    checkKeys("R10 wipe xor");
    @(negedge clk); engineIdle = 1'b0;
    busWrite(ADDR_WIPE, 32'hF0F0_0F0F);
    for (int i = 0; i < NumKeyWords; i++) mKey[i] ^= 32'hF0F0_0F0F;
    checkKeys("R10 wipe busy");
    engineIdle = 1'b1;
  endtask

  task automatic tReadZero;
    logic [31:0] r;
    busRead(KEY_BASE, r);
    chk("R11 key0 reads zero", r, 32'h0);
    busRead(KEY_BASE + 7'd31, r);
    chk("R11 key31 reads zero", r, 32'h0);
    busRead(ADDR_WIPE, r);
    chk("R11 wipe reads zero", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tReset;
    tCfgFields;
    tDigestNorm;
    tKeyLenNorm;
    tCap;
    tCfgLock;
    tKeyOrder;
    tKeyBusy;
    tCmd;
    tWipe;
    tReadZero;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule